// File: doc/BRIEF.md
# Interval Timer and Interrupt Register Bank

This block is a byte-wide bank of sixteen peripheral registers, selected by a 4-bit index. It holds two port data bytes, two port direction bytes, a shift data byte, and an auxiliary and a peripheral control byte. It also holds a reloading 16-bit interval timer, a 16-bit one-shot timer, and a flag/enable pair that drives a single level interrupt. Both timers count down once for each cycle in which the tick enable input is high. The rate of that input therefore sets the timer clock.

Software works the bank through a one-cycle read or write strobe. Some timer and shift accesses have side effects: they clear flags or load counters. The interval timer repeats only while the auxiliary control byte selects the continuous mode. The shift flag is set from outside through an event input, which connects the bank to a serial transfer engine that lives elsewhere.

Top module: `via_regblk`

## Requirements
- R1: After reset, every data, direction, shift and control byte, the flag byte and the enable byte read as zero. The interval timer latch and counter read 0xFFFF, the one-shot counter reads 0xFFFF, its stored low latch byte is 0, and irq is low.
- R2: Register index map: 0 is port B, 1 is port A, 2 is direction B, 3 is direction A, 10 is the shift byte, 11 is auxiliary control and 12 is peripheral control. Each of these reads back the byte last written to it. Index 15 is a second window onto port A, for both reads and writes. The port and direction bytes also drive pa_q, pb_q, pa_dir and pb_dir.
- R3: Interval timer bytes: indices 4 and 6 write the latch low byte, and reading them returns the counter low byte and the latch low byte respectively. A write to index 5 sets the latch high byte, clears flag bit 6 and loads the counter with {written byte, latch low}. A write to index 7 sets the latch high byte and clears flag bit 6, but leaves the counter unchanged. Reading index 5 returns the counter high byte, and reading index 7 returns the latch high byte.
- R4: With auxiliary control bits [7:6] = 01, the interval counter steps down each tick: latch, ..., 0, 0xFFFF, then the latch again. One period is latch+2 ticks. Flag bit 6 is set on each tick that brings the count to 0.
- R5: With auxiliary control bits [7:6] other than 01, the interval counter keeps decrementing and wraps from 0 to 0xFFFF to 0xFFFE without reloading, and flag bit 6 is never set.
- R6: A write to index 8 stores the one-shot low latch byte only. A write to index 9 loads the one-shot counter with {written byte, stored low byte} and arms it. Indices 8 and 9 read the counter low and high bytes. The counter decrements each tick. Flag bit 5 is set once, on the tick that brings an armed count to 0, and is not set again until the next load.
- R7: Reading index 4 clears flag bit 6, reading index 8 clears flag bit 5, and reading index 10 clears flag bit 2. Reading index 5 clears no flag.
- R8: Writing index 13 clears each flag bit in [6:0] that is written as 1.
- R9: Reading index 13 returns the flags in [6:0], with bit 7 set when any flag is both set and enabled.
- R10: Writing index 14 with bit 7 = 1 ORs bits [6:0] into the enables. With bit 7 = 0, it clears each enable bit written as 1. Reading index 14 returns the enables with bit 7 forced to 1.
- R11: irq is high exactly when flag bit 6 or flag bit 2 is both set and enabled. Flag bit 5 never drives irq. irq changes on the same clock edge as the flags.
- R12: A cycle with sh_evt high sets flag bit 2. When a clear and a set of the same flag fall in one cycle, the set wins.
- R13: rdata is registered. It shows the selected register as it was before the edge that samples rd_en, and it holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer count enable, one decrement per high cycle |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| reg_idx | input | 4 | Register index |
| wdata | input | 8 | Write data |
| sh_evt | input | 1 | Shift transfer event, sets flag bit 2 |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |
| pa_q | output | 8 | Port A data byte |
| pb_q | output | 8 | Port B data byte |
| pa_dir | output | 8 | Port A direction byte |
| pb_dir | output | 8 | Port B direction byte |

## Verification
A counter that reloads one tick early or late shows up in the tick at which flag bit 6 and irq rise, and in the byte read back one tick after the count passes zero. A reload at 0 instead of after 0xFFFF shows within the second period. A wrong side-effect decode leaves a flag standing or clears it, and this is visible in the very next read of index 13 and at irq on the edge after the access. A broken one-shot arm shows as a flag that never rises, or as one that rises again after it has been cleared.

// File: rtl/via_pkg.sv
package via_pkg;
  localparam logic [3:0] IX_PB   = 4'd0;
  localparam logic [3:0] IX_PA   = 4'd1;
  localparam logic [3:0] IX_DB   = 4'd2;
  localparam logic [3:0] IX_DA   = 4'd3;
  localparam logic [3:0] IX_T1CL = 4'd4;
  localparam logic [3:0] IX_T1CH = 4'd5;
  localparam logic [3:0] IX_T1LL = 4'd6;
  localparam logic [3:0] IX_T1LH = 4'd7;
  localparam logic [3:0] IX_T2L  = 4'd8;
  localparam logic [3:0] IX_T2H  = 4'd9;
  localparam logic [3:0] IX_SHF  = 4'd10;
  localparam logic [3:0] IX_AUX  = 4'd11;
  localparam logic [3:0] IX_PCT  = 4'd12;
  localparam logic [3:0] IX_FLG  = 4'd13;
  localparam logic [3:0] IX_ENA  = 4'd14;
  localparam logic [3:0] IX_PAN  = 4'd15;

  localparam int FB_T1 = 6;
  localparam int FB_T2 = 5;
  localparam int FB_SH = 2;
  localparam logic [1:0] T1_CONT = 2'b01;
endpackage

// File: rtl/via_timer_rel.sv
module via_timer_rel #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cont,
  input  logic          wr_lo,
  input  logic          wr_hi_load,
  input  logic          wr_hi_only,
  input  logic [TW/2-1:0] wbyte,
  output logic [TW-1:0] cnt_o,
  output logic [TW-1:0] latch_o,
  output logic          zero_o
);
  localparam int HW = TW / 2;
  logic [TW-1:0] cnt_q, latch_q;
  logic          wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '1;
      latch_q <= '1;
      wrap_q  <= 1'b0;
    end else begin
      if (wr_lo) latch_q[HW-1:0] <= wbyte;
      if (wr_hi_load || wr_hi_only) latch_q[TW-1:HW] <= wbyte;
      if (wr_hi_load) begin
        cnt_q  <= {wbyte, latch_q[HW-1:0]};
        wrap_q <= 1'b0;
      end else if (tick) begin
        if (cont && wrap_q) begin
          cnt_q  <= latch_q;
          wrap_q <= 1'b0;
        end else begin
          cnt_q  <= cnt_q - 1'b1;
          wrap_q <= (cnt_q == '0);
        end
      end
    end
  end

  assign zero_o  = !wr_hi_load && tick && cont &&
                   ((wrap_q && latch_q == '0) || (!wrap_q && cnt_q == TW'(1)));
  assign cnt_o   = cnt_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/via_timer_one.sv
module via_timer_one #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [TW/2-1:0] wbyte,
  output logic [TW-1:0] cnt_o,
  output logic          zero_o
);
  localparam int HW = TW / 2;
  logic [TW-1:0] cnt_q;
  logic [HW-1:0] lo_q;
  logic          armed_q;

  assign zero_o = !wr_hi && tick && armed_q && (cnt_q == TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '1;
      lo_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_lo) lo_q <= wbyte;
      if (wr_hi) begin
        cnt_q   <= {wbyte, lo_q};
        armed_q <= 1'b1;
      end else if (tick) begin
        cnt_q <= cnt_q - 1'b1;
        if (zero_o) armed_q <= 1'b0;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/via_irq_ctl.sv
module via_irq_ctl #(
  parameter int FW = 7,
  parameter logic [FW-1:0] IRQ_MASK = 7'h44
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] set_i,
  input  logic [FW-1:0] clr_i,
  input  logic          ena_wr,
  input  logic [FW:0]   wbyte,
  output logic [FW-1:0] flg_o,
  output logic [FW-1:0] ena_o,
  output logic          irq_o
);
  logic [FW-1:0] flg_q, ena_q, flg_n, ena_n;

  always_comb begin
    flg_n = (flg_q & ~clr_i) | set_i;
    ena_n = ena_q;
    if (ena_wr) begin
      if (wbyte[FW]) ena_n = ena_q | wbyte[FW-1:0];
      else           ena_n = ena_q & ~wbyte[FW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q <= '0;
      ena_q <= '0;
      irq_o <= 1'b0;
    end else begin
      flg_q <= flg_n;
      ena_q <= ena_n;
      irq_o <= |(flg_n & ena_n & IRQ_MASK);
    end
  end

  assign flg_o = flg_q;
  assign ena_o = ena_q;
endmodule

// File: rtl/via_regblk.sv
module via_regblk
  import via_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [IW-1:0] reg_idx,
  input  logic [DW-1:0] wdata,
  input  logic          sh_evt,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic [DW-1:0] pa_q,
  output logic [DW-1:0] pb_q,
  output logic [DW-1:0] pa_dir,
  output logic [DW-1:0] pb_dir
);
  localparam int TW = 2 * DW;
  localparam int FW = DW - 1;

  logic [DW-1:0] shf_q, aux_q, pct_q;
  logic [TW-1:0] t1_cnt, t1_latch, t2_cnt;
  logic          t1_zero, t2_zero;
  logic [FW-1:0] flg_q, ena_q, set_v, clr_v;

  function automatic logic hit(input logic en, input logic [IW-1:0] a, input logic [3:0] b);
    return en && (a == IW'(b));
  endfunction

  via_timer_rel #(.TW(TW)) u_t1 (
    .clk(clk), .rst(rst), .tick(tick_en),
    .cont(aux_q[DW-1:DW-2] == T1_CONT),
    .wr_lo(hit(wr_en, reg_idx, IX_T1CL) || hit(wr_en, reg_idx, IX_T1LL)),
    .wr_hi_load(hit(wr_en, reg_idx, IX_T1CH)),
    .wr_hi_only(hit(wr_en, reg_idx, IX_T1LH)),
    .wbyte(wdata), .cnt_o(t1_cnt), .latch_o(t1_latch), .zero_o(t1_zero)
  );

  via_timer_one #(.TW(TW)) u_t2 (
    .clk(clk), .rst(rst), .tick(tick_en),
    .wr_lo(hit(wr_en, reg_idx, IX_T2L)),
    .wr_hi(hit(wr_en, reg_idx, IX_T2H)),
    .wbyte(wdata), .cnt_o(t2_cnt), .zero_o(t2_zero)
  );

  always_comb begin
    set_v = '0;
    set_v[FB_T1] = t1_zero;
    set_v[FB_T2] = t2_zero;
    set_v[FB_SH] = sh_evt;
    clr_v = hit(wr_en, reg_idx, IX_FLG) ? wdata[FW-1:0] : '0;
    if (hit(wr_en, reg_idx, IX_T1CH) || hit(wr_en, reg_idx, IX_T1LH) ||
        hit(rd_en, reg_idx, IX_T1CL))
      clr_v[FB_T1] = 1'b1;
    if (hit(rd_en, reg_idx, IX_T2L)) clr_v[FB_T2] = 1'b1;
    if (hit(rd_en, reg_idx, IX_SHF)) clr_v[FB_SH] = 1'b1;
  end

  via_irq_ctl #(.FW(FW), .IRQ_MASK(FW'(7'h44))) u_irq (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v),
    .ena_wr(hit(wr_en, reg_idx, IX_ENA)), .wbyte(wdata),
    .flg_o(flg_q), .ena_o(ena_q), .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_q <= '0; pb_q <= '0; pa_dir <= '0; pb_dir <= '0;
      shf_q <= '0; aux_q <= '0; pct_q <= '0;
    end else if (wr_en) begin
      case (reg_idx)
        IX_PB:         pb_q   <= wdata;
        IX_PA, IX_PAN: pa_q   <= wdata;
        IX_DB:         pb_dir <= wdata;
        IX_DA:         pa_dir <= wdata;
        IX_SHF:        shf_q  <= wdata;
        IX_AUX:        aux_q  <= wdata;
        IX_PCT:        pct_q  <= wdata;
        default: ;
      endcase
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    case (reg_idx)
      IX_PB:   rd_mux = pb_q;
      IX_PA:   rd_mux = pa_q;
      IX_DB:   rd_mux = pb_dir;
      IX_DA:   rd_mux = pa_dir;
      IX_T1CL: rd_mux = t1_cnt[DW-1:0];
      IX_T1CH: rd_mux = t1_cnt[TW-1:DW];
      IX_T1LL: rd_mux = t1_latch[DW-1:0];
      IX_T1LH: rd_mux = t1_latch[TW-1:DW];
      IX_T2L:  rd_mux = t2_cnt[DW-1:0];
      IX_T2H:  rd_mux = t2_cnt[TW-1:DW];
      IX_SHF:  rd_mux = shf_q;
      IX_AUX:  rd_mux = aux_q;
      IX_PCT:  rd_mux = pct_q;
      IX_FLG:  rd_mux = {|(flg_q & ena_q), flg_q};
      IX_ENA:  rd_mux = {1'b1, ena_q};
      default: rd_mux = pa_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/via_regblk_chk.sv
module via_regblk_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        rd_en,
  input logic [3:0]  reg_idx,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        irq,
  input logic [6:0]  flg_q,
  input logic [6:0]  ena_q,
  input logic [15:0] t1_cnt,
  input logic [15:0] t1_latch,
  input logic [15:0] t2_cnt,
  input logic        t1_zero
);
  AST_T1_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_idx == 4'd5) |=> t1_cnt == {$past(wdata), $past(t1_latch[7:0])}); // R3
  AST_T1_HI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (reg_idx == 4'd5 || reg_idx == 4'd7) && !t1_zero) |=> !flg_q[6]); // R3
  AST_T2_ONE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(flg_q[5]) |-> $past(t2_cnt) == 16'd1); // R6
  AST_SUMMARY_BIT: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_idx == 4'd13) |=> rdata[7] == $past(|(flg_q & ena_q))); // R9
  AST_ENA_TOP_SET: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_idx == 4'd14) |=> rdata[7]); // R10
  AST_IRQ_SOURCES: assert property (@(posedge clk) disable iff (rst)
    irq == ((flg_q[6] && ena_q[6]) || (flg_q[2] && ena_q[2]))); // R11
endmodule

bind via_regblk via_regblk_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx),
  .wdata(wdata), .rdata(rdata), .irq(irq), .flg_q(flg_q), .ena_q(ena_q),
  .t1_cnt(t1_cnt), .t1_latch(t1_latch), .t2_cnt(t2_cnt), .t1_zero(t1_zero)
);

// File: tb/via_regblk_bench.sv
`timescale 1ns/1ps
module via_regblk_bench;
  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, sh_evt = 1'b0;
  logic [3:0] reg_idx = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pa_q, pb_q, pa_dir, pb_dir;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  via_regblk u_via_regblk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .reg_idx(reg_idx), .wdata(wdata), .sh_evt(sh_evt), .rdata(rdata), .irq(irq),
    .pa_q(pa_q), .pb_q(pb_q), .pa_dir(pa_dir), .pb_dir(pb_dir)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; reg_idx = i; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdc(input logic [3:0] i, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; reg_idx = i;
    @(negedge clk); rd_en = 1'b0;
    chk(tag, {8'h0, rdata}, {8'h0, exp});
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  function automatic logic [3:0] plain_idx(input int sel);
    case (sel)
      0: return 4'd0;  1: return 4'd1;  2: return 4'd2;
      3: return 4'd3;  4: return 4'd10; default: return 4'd12;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] lv, rv, b;
    logic [3:0] ix;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 ports", {pa_q, pb_q}, 16'h0);
    rdc(4'd4, 8'hFF, "R1 t1 cnt lo"); rdc(4'd5, 8'hFF, "R1 t1 cnt hi");
    rdc(4'd6, 8'hFF, "R1 t1 latch lo"); rdc(4'd7, 8'hFF, "R1 t1 latch hi");
    rdc(4'd8, 8'hFF, "R1 t2 lo"); rdc(4'd9, 8'hFF, "R1 t2 hi");
    rdc(4'd13, 8'h00, "R1 flags"); rdc(4'd14, 8'h80, "R1 enables");
    rdc(4'd11, 8'h00, "R1 aux"); rdc(4'd0, 8'h00, "R1 port B");

    // R2 random plain register traffic
    for (int k = 0; k < 16; k++) begin
      ix = plain_idx($urandom_range(0, 5));
      b  = 8'($urandom);
      wr(ix, b);
      rdc(ix, b, "R2 readback");
      if (ix == 4'd0) chk("R2 pb_q", {8'h0, pb_q}, {8'h0, b});
      if (ix == 4'd1) chk("R2 pa_q", {8'h0, pa_q}, {8'h0, b});
      if (ix == 4'd2) chk("R2 pb_dir", {8'h0, pb_dir}, {8'h0, b});
      if (ix == 4'd3) chk("R2 pa_dir", {8'h0, pa_dir}, {8'h0, b});
    end
    b = 8'($urandom);
    wr(4'd15, b);
    rdc(4'd1, b, "R2 index 15 writes port A");
    chk("R2 pa_q via 15", {8'h0, pa_q}, {8'h0, b});
    rdc(4'd15, b, "R2 index 15 reads port A");

    // R4 continuous interval timer
    wr(4'd11, 8'h40);
    wr(4'd14, 8'hC0);
    lv = 8'($urandom_range(3, 20));
    wr(4'd4, lv); wr(4'd5, 8'h00);
    rdc(4'd4, lv, "R3 load from latch lo");
    tick(lv - 1);
    rdc(4'd13, 8'h00, "R4 no flag before zero");
    chk("R4 irq low before zero", {15'h0, irq}, 16'h0);
    tick(1);
    chk("R4 R11 irq at zero", {15'h0, irq}, 16'h1);
    rdc(4'd13, 8'hC0, "R4 R9 flag and summary");
    rdc(4'd5, 8'h00, "R7 read hi keeps flag");
    rdc(4'd13, 8'hC0, "R7 flag after hi read");
    rdc(4'd4, 8'h00, "R7 read lo count zero");
    chk("R7 irq cleared by lo read", {15'h0, irq}, 16'h0);
    rdc(4'd13, 8'h00, "R7 flag cleared");
    tick(1);
    rdc(4'd5, 8'hFF, "R4 wraps past zero hi");
    rdc(4'd4, 8'hFF, "R4 wraps past zero lo");
    tick(1);
    rdc(4'd4, lv, "R4 reload after latch+2");
    rdc(4'd5, 8'h00, "R4 reload hi");
    tick(lv);
    chk("R4 second period irq", {15'h0, irq}, 16'h1);

    // R8 flag write clear
    wr(4'd13, 8'h40);
    chk("R8 irq after clear", {15'h0, irq}, 16'h0);
    rdc(4'd13, 8'h00, "R8 flag cleared");

    // R3 latch high write without load
    tick(lv + 2);
    chk("R4 third period irq", {15'h0, irq}, 16'h1);
    wr(4'd7, 8'h12);
    chk("R3 latch hi clears irq", {15'h0, irq}, 16'h0);
    rdc(4'd13, 8'h00, "R3 latch hi clears flag");
    rdc(4'd6, lv, "R3 latch lo kept");
    rdc(4'd7, 8'h12, "R3 latch hi stored");
    rdc(4'd5, 8'h00, "R3 counter not loaded");
    wr(4'd6, 8'h34);
    rdc(4'd4, 8'h00, "R3 latch lo write leaves counter");
    rdc(4'd6, 8'h34, "R3 latch lo via 6");
    wr(4'd5, 8'h01);
    rdc(4'd4, 8'h34, "R3 load lo");
    rdc(4'd5, 8'h01, "R3 load hi");

    // R5 non-continuous mode
    wr(4'd11, 8'h00);
    wr(4'd4, 8'h02); wr(4'd5, 8'h00);
    tick(4);
    rdc(4'd13, 8'h00, "R5 no flag");
    chk("R5 irq low", {15'h0, irq}, 16'h0);
    rdc(4'd4, 8'hFE, "R5 free wrap lo");
    rdc(4'd5, 8'hFF, "R5 free wrap hi");

    // R10 enable encoding
    wr(4'd14, 8'h7F);
    rdc(4'd14, 8'h80, "R10 clear all");
    wr(4'd14, 8'h85);
    rdc(4'd14, 8'h85, "R10 set bits");
    wr(4'd14, 8'h04);
    rdc(4'd14, 8'h81, "R10 clear bit 2");
    wr(4'd14, 8'h7F);

    // R6 one-shot timer
    rv = 8'($urandom_range(2, 15));
    wr(4'd8, rv);
    rdc(4'd9, 8'hFF, "R6 low write does not load");
    wr(4'd9, 8'h00);
    rdc(4'd8, rv, "R6 load lo");
    rdc(4'd9, 8'h00, "R6 load hi");
    tick(rv - 1);
    rdc(4'd13, 8'h00, "R6 no flag before zero");
    tick(1);
    rdc(4'd13, 8'h20, "R6 flag at zero, R9 no summary");
    wr(4'd14, 8'hA0);
    rdc(4'd13, 8'hA0, "R9 summary with enable");
    chk("R11 bit 5 does not drive irq", {15'h0, irq}, 16'h0);
    rdc(4'd8, 8'h00, "R7 t2 lo read");
    rdc(4'd13, 8'h00, "R7 t2 flag cleared");
    tick(3);
    rdc(4'd13, 8'h00, "R6 one-shot no re-raise");
    rdc(4'd9, 8'hFF, "R6 wrapped hi");
    rdc(4'd8, 8'hFD, "R6 wrapped lo");

    // R12 shift event
    wr(4'd14, 8'h7F); wr(4'd14, 8'h84);
    wr(4'd10, 8'h5A);
    @(negedge clk); sh_evt = 1'b1;
    @(negedge clk); sh_evt = 1'b0;
    chk("R12 R11 irq from shift", {15'h0, irq}, 16'h1);
    rdc(4'd13, 8'h84, "R12 shift flag");
    rdc(4'd10, 8'h5A, "R7 shift read");
    chk("R7 shift read drops irq", {15'h0, irq}, 16'h0);
    rdc(4'd13, 8'h00, "R7 shift flag cleared");
    @(negedge clk); sh_evt = 1'b1; wr_en = 1'b1; reg_idx = 4'd13; wdata = 8'h04;
    @(negedge clk); sh_evt = 1'b0; wr_en = 1'b0;
    rdc(4'd13, 8'h84, "R12 set beats clear");

    // R13 read data holds
    wr(4'd0, 8'h77);
    wr(4'd12, 8'h33);
    chk("R13 rdata holds", {8'h0, rdata}, 16'h0084);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule